// File: doc/BRIEF.md
# Transition-Event Wire Emulator

This block models, in discrete time, a lossy interconnect that carries a digital bit stream. On every enabled sample it compares the incoming bit with the level it last saw. A change of level is logged as an event: the new level, its direction and the sample index at which it occurred. Each output sample is a settled baseline plus the sum of tabulated step responses. There is one step response per logged event, looked up at the event's age and signed by its direction. The sum is then compared against a threshold to recover a bit.

Events are kept in a short time-ordered queue. When an event has aged past the end of its table, it leaves the queue and its final level is folded into the baseline. The work per sample is therefore bounded by the queue depth, not by the length of the stream. Rising and falling edges each have their own response table, given as synthesizable parameter arrays in signed fixed point. The block is intended for fast behavioural emulation of a wire segment inside a larger digital model.

Top module: `line_emu`

## Requirements
- R1: After reset, `y_o` is 0, `bit_o` is 0 and `ovf_o` is 0. The baseline is 0 and the last seen input level is 0.
- R2: An event is logged only on a sample where `en_i` is 1 and `din_i` differs from the level seen at the previous enabled sample. Changes of `din_i` while `en_i` is 0 have no effect.
- R3: The sample equals the baseline plus a term for each queued event. For an event of age a (samples since it was logged, with 0 on the sample that logs it), the term is +RISE_TAB[a] for a 0-to-1 event and -FALL_TAB[a] for a 1-to-0 event.
- R4: An event whose age reaches TAB_LEN at the start of an enabled sample leaves the queue on that sample. The baseline becomes RISE_TAB[TAB_LEN-1] if the event was a 0-to-1 change, or 0 if it was a 1-to-0 change.
- R5: The baseline changes only on a sample where an event leaves the queue. With a steady input, once every event has left the queue the output holds at the baseline.
- R6: The queue holds DEPTH events. When a new event arrives while the queue is still full after any age-based removal, the oldest event is removed first and folded into the baseline as in R4. `ovf_o` then goes to 1 and stays at 1 until reset.
- R7: `bit_o` is 1 exactly when the registered sample `y_o`, read as signed, is greater than or equal to THRESH. It updates on the same edge as `y_o`.
- R8: `y_o`, `bit_o` and `ovf_o` are registered. They change only on the clock edge that samples `en_i` at 1, and they hold otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Sample enable; one emulated time step per cycle it is high |
| din_i | input | 1 | Transmitted bit |
| y_o | output | ACC_W | Signed emulated line voltage (fixed point, same scale as the tables) |
| bit_o | output | 1 | Recovered bit after the threshold comparator |
| ovf_o | output | 1 | Sticky flag: an event was retired early because the queue was full |

## Verification
The assertions assume that the step enable and input bit are driven synchronously and that reset is asserted before the first enabled sample. Under that assumption, ages grow by exactly one per enabled sample, so at most one event can become due on any sample. The queue bound holds only when no more than DEPTH transitions fall inside any TAB_LEN-sample window. Most of the stimulus keeps inside that bound, including a toggle every second sample that fills the queue exactly. A separate phase, after a fresh reset, toggles on every sample on purpose to drive the forced-retirement path.

// File: rtl/line_emu_pkg.sv
package line_emu_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } edge_e;

    // accumulator must hold baseline plus DEPTH+1 table terms without wrapping
    function automatic int acc_width(input int w, input int depth);
        return w + $clog2(depth + 2) + 1;
    endfunction

endpackage

// File: rtl/line_emu_edge.sv
module line_emu_edge
    import line_emu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  din,
    output edge_e edge_o
);

    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d  = lvl_q;
        edge_o = EDGE_NONE;
        if (en) begin
            lvl_d = din;
            if (din != lvl_q) edge_o = din ? EDGE_RISE : EDGE_FALL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    // R2: successive events alternate in direction
    edge_e last_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                 last_q <= EDGE_FALL;
        else if (edge_o != EDGE_NONE) last_q <= edge_o;
    end

    p_edge_alternates_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_o != EDGE_NONE) |-> (edge_o != last_q));

endmodule

// File: rtl/line_emu_queue.sv
module line_emu_queue #(
    parameter int DEPTH = 4,
    parameter int TSW   = 5,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic           push_rise,
    input  logic [TSW-1:0] push_ts,
    input  logic           pop,
    output logic [DEPTH-1:0] vld_o,
    output logic [DEPTH-1:0] rise_o,
    output logic [TSW-1:0] ts_o [DEPTH],
    output logic [CW-1:0]  cnt_o
);

    typedef struct packed {
        logic           vld;
        logic           rise;
        logic [TSW-1:0] ts;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
        logic  [CW-1:0]    cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic [CW-1:0] wr;
        st_d = st_q;
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) st_d.slot[i] = st_q.slot[i+1];
            st_d.slot[DEPTH-1] = '0;
            st_d.cnt = st_q.cnt - 1'b1;
        end
        wr = st_d.cnt;
        if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr == CW'(i)) st_d.slot[i] = '{vld: 1'b1, rise: push_rise, ts: push_ts};
            end
            st_d.cnt = wr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_out
        assign vld_o[g]  = st_q.slot[g].vld;
        assign rise_o[g] = st_q.slot[g].rise;
        assign ts_o[g]   = st_q.slot[g].ts;
    end
    assign cnt_o = st_q.cnt;

    // R6: a push never lands on a full queue unless a slot is freed the same cycle
    p_room_on_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (st_q.cnt < CW'(DEPTH)));

    // R4: removal only from a non-empty queue
    p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.cnt != '0));

endmodule

// File: rtl/line_emu_tap.sv
module line_emu_tap #(
    parameter int W       = 16,
    parameter int TAB_LEN = 8,
    parameter int TSW     = 5,
    parameter int ACC_W   = 20,
    parameter logic signed [W-1:0] RISE_TAB [TAB_LEN] = '{default: '0},
    parameter logic signed [W-1:0] FALL_TAB [TAB_LEN] = '{default: '0},
    localparam int IW     = $clog2(TAB_LEN)
) (
    input  logic                    vld,
    input  logic                    rise,
    input  logic [TSW-1:0]          age,
    output logic signed [ACC_W-1:0] term_o
);

    logic [IW-1:0]         idx;
    logic signed [W-1:0]   mag;
    logic signed [ACC_W-1:0] ext;

    always_comb begin
        idx    = (age >= TSW'(TAB_LEN)) ? IW'(TAB_LEN - 1) : age[IW-1:0];
        mag    = rise ? RISE_TAB[idx] : FALL_TAB[idx];
        ext    = ACC_W'(mag);
        term_o = '0;
        if (vld) term_o = rise ? ext : -ext;
    end

endmodule

// File: rtl/line_emu.sv
module line_emu
    import line_emu_pkg::*;
#(
    parameter int W       = 16,
    parameter int TAB_LEN = 8,
    parameter int DEPTH   = 4,
    parameter int THRESH  = 512,
    parameter logic signed [W-1:0] RISE_TAB [TAB_LEN] =
        '{16'sd0, 16'sd200, 16'sd500, 16'sd750, 16'sd900, 16'sd980, 16'sd1015, 16'sd1024},
    parameter logic signed [W-1:0] FALL_TAB [TAB_LEN] =
        '{16'sd0, 16'sd300, 16'sd600, 16'sd820, 16'sd940, 16'sd1000, 16'sd1020, 16'sd1024},
    localparam int TSW   = $clog2(TAB_LEN) + 2,
    localparam int ACC_W = acc_width(W, DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic                    din_i,
    output logic signed [ACC_W-1:0] y_o,
    output logic                    bit_o,
    output logic                    ovf_o
);

    localparam logic signed [ACC_W-1:0] SETTLE = ACC_W'(RISE_TAB[TAB_LEN-1]);
    localparam logic signed [ACC_W-1:0] THR    = ACC_W'(THRESH);

    typedef struct packed {
        logic [TSW-1:0]          now;
        logic signed [ACC_W-1:0] k1;
        logic signed [ACC_W-1:0] y;
        logic                    bit_v;
        logic                    ovf;
    } st_t;

    st_t st_d, st_q;

    edge_e            edge_s;
    logic [DEPTH-1:0] q_vld, q_rise;
    logic [TSW-1:0]   q_ts [DEPTH];
    logic [CW-1:0]    q_cnt;
    logic [TSW-1:0]   head_age;
    logic             is_edge, age_pop, force_pop, pop;

    logic [DEPTH:0]          tap_vld, tap_rise;
    logic [TSW-1:0]          tap_age [DEPTH+1];
    logic signed [ACC_W-1:0] term    [DEPTH+1];

    line_emu_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en_i),
        .din    (din_i),
        .edge_o (edge_s)
    );

    assign is_edge   = (edge_s != EDGE_NONE);
    assign head_age  = st_q.now - q_ts[0];
    assign age_pop   = en_i && q_vld[0] && (head_age >= TSW'(TAB_LEN));
    assign force_pop = is_edge && (q_cnt == CW'(DEPTH)) && !age_pop;
    assign pop       = age_pop || force_pop;

    line_emu_queue #(.DEPTH(DEPTH), .TSW(TSW)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (is_edge),
        .push_rise (edge_s == EDGE_RISE),
        .push_ts   (st_q.now),
        .pop       (pop),
        .vld_o     (q_vld),
        .rise_o    (q_rise),
        .ts_o      (q_ts),
        .cnt_o     (q_cnt)
    );

    // one tap per queued event, plus one for the event logged this sample
    for (genvar g = 0; g <= DEPTH; g++) begin : g_tap
        if (g < DEPTH) begin : g_slot
            assign tap_vld[g]  = q_vld[g] && !(pop && (g == 0));
            assign tap_rise[g] = q_rise[g];
            assign tap_age[g]  = st_q.now - q_ts[g];
        end else begin : g_new
            assign tap_vld[g]  = is_edge;
            assign tap_rise[g] = (edge_s == EDGE_RISE);
            assign tap_age[g]  = '0;
        end
        line_emu_tap #(
            .W(W), .TAB_LEN(TAB_LEN), .TSW(TSW), .ACC_W(ACC_W),
            .RISE_TAB(RISE_TAB), .FALL_TAB(FALL_TAB)
        ) u_tap (
            .vld    (tap_vld[g]),
            .rise   (tap_rise[g]),
            .age    (tap_age[g]),
            .term_o (term[g])
        );
    end

    always_comb begin
        logic signed [ACC_W-1:0] acc;
        st_d = st_q;
        acc  = '0;
        if (en_i) begin
            st_d.now = st_q.now + 1'b1;
            if (pop) st_d.k1 = q_rise[0] ? SETTLE : '0;
            if (force_pop) st_d.ovf = 1'b1;
            acc = st_d.k1;
            for (int i = 0; i <= DEPTH; i++) acc = acc + term[i];
            st_d.y     = acc;
            st_d.bit_v = (acc >= THR);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign y_o   = st_q.y;
    assign bit_o = st_q.bit_v;
    assign ovf_o = st_q.ovf;

    // R5: the baseline moves only when an event leaves the queue
    p_k1_on_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pop |=> $stable(st_q.k1));

    // R8: outputs hold on samples without enable
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ($stable(y_o) && $stable(bit_o) && $stable(ovf_o)));

    // R6: overflow flag is sticky
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    // R4: the head is never more than one sample overdue
    p_head_age_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q_vld[0] |-> (head_age <= TSW'(TAB_LEN)));

    // R7: recovered bit agrees with the registered sample
    p_bit_thresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_o == (y_o >= THR));

endmodule

// File: tb/tb_line_emu.sv
module tb_line_emu;

    localparam int W       = 16;
    localparam int TAB_LEN = 8;
    localparam int DEPTH   = 4;
    localparam int THRESH  = 512;
    localparam int ACC_W   = W + $clog2(DEPTH + 2) + 1;
    localparam logic signed [W-1:0] RT [TAB_LEN] =
        '{16'sd0, 16'sd150, 16'sd420, 16'sd700, 16'sd880, 16'sd970, 16'sd1010, 16'sd1024};
    localparam logic signed [W-1:0] FT [TAB_LEN] =
        '{16'sd0, 16'sd260, 16'sd580, 16'sd800, 16'sd930, 16'sd990, 16'sd1018, 16'sd1024};

    logic clk = 1'b0;
    logic rst_n, en_i, din_i;
    logic signed [ACC_W-1:0] y_o;
    logic bit_o, ovf_o;

    always #5 clk = ~clk;

    line_emu #(
        .W(W), .TAB_LEN(TAB_LEN), .DEPTH(DEPTH), .THRESH(THRESH),
        .RISE_TAB(RT), .FALL_TAB(FT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .din_i(din_i),
        .y_o(y_o), .bit_o(bit_o), .ovf_o(ovf_o)
    );

    int n_chk = 0;
    int n_bad = 0;

    // behavioural reference
    typedef struct { int ts; bit rise; } rec_t;
    rec_t mq[$];
    int   m_now, m_k1, exp_y;
    bit   m_lvl, m_ovf, exp_bit;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        mq.delete();
        m_now = 0; m_k1 = 0; m_lvl = 0; m_ovf = 0; exp_y = 0; exp_bit = 0;
    endtask

    task automatic retire_head();
        m_k1 = mq[0].rise ? int'(RT[TAB_LEN-1]) : 0;
        void'(mq.pop_front());
    endtask

    task automatic model_step(input bit e, input bit d);
        int sum;
        if (!e) return;
        if (mq.size() > 0 && (m_now - mq[0].ts) >= TAB_LEN) retire_head();
        if (d != m_lvl) begin
            if (mq.size() == DEPTH) begin
                retire_head();
                m_ovf = 1;
            end
            mq.push_back('{m_now, d});
        end
        m_lvl = d;
        sum = m_k1;
        foreach (mq[i]) begin
            int a = m_now - mq[i].ts;
            sum += mq[i].rise ? int'(RT[a]) : -int'(FT[a]);
        end
        exp_y = sum;
        exp_bit = (sum >= THRESH);
        m_now++;
    endtask

    // called at a falling edge; compares after the next rising edge
    task automatic step(input bit e, input bit d, input string tag);
        en_i = e; din_i = d;
        model_step(e, d);
        @(negedge clk);
        check(tag, int'(y_o), exp_y);
        check("R7", int'(bit_o), int'(exp_bit));
        check("R6", int'(ovf_o), int'(m_ovf));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; en_i = 1'b0; din_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check("R1", int'(y_o), 0);
        check("R1", int'(bit_o), 0);
        check("R1", int'(ovf_o), 0);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; en_i = 1'b0; din_i = 1'b0;
        @(negedge clk);
        do_reset();

        // R2: input toggles without enable are ignored
        for (int i = 0; i < 4; i++) step(1'b0, i[0], "R2");
        step(1'b1, 1'b0, "R2");

        // R3 then R4/R5: single rise, settle to baseline
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1, i < 8 ? "R3" : "R5");
        // single fall, settle to zero
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0, i < 8 ? "R3" : "R4");

        // short pulse: rise then fall on consecutive samples
        step(1'b1, 1'b1, "R3");
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, "R3");

        // R3: slow square wave, period 10 samples
        for (int i = 0; i < 40; i++) step(1'b1, ((i / 5) % 2) == 0, "R3");

        // R6 boundary: toggle every second sample fills the queue exactly
        for (int i = 0; i < 24; i++) step(1'b1, ((i / 2) % 2) == 1, "R6");

        // R8: enable gaps interleaved with input changes
        for (int i = 0; i < 20; i++) step(i % 3 != 0, ((i / 4) % 2) == 1, "R8");
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, "R4");

        // R6: toggle every sample forces early retirement
        do_reset();
        for (int i = 0; i < 16; i++) step(1'b1, i[0] == 1'b0, "R6");
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1, "R5");
        for (int i = 0; i < 4; i++)  step(1'b0, 1'b0, "R8");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule